// File: doc/BRIEF.md
# Hub Repeater Speed and Preamble Gating

This block decides, one full-speed bit time at a time, which drivers of a hub with one upstream and several downstream ports are turned on. It sees the sampled line state of every port, a stream of decoded packet identifiers from upstream, and a strobe that marks each full-speed bit time. From these it works out the direction of each packet. Traffic that starts upstream is repeated to the enabled downstream ports. Traffic that starts on an enabled downstream port is sent upstream, and the upstream driver is always a full-speed driver.

A port's speed is taken at attach time from which data line its device pulls high. Low-speed ports stay silent during normal downstream traffic. They are opened only after the preamble identifier arrives during a downstream packet. The opening comes a fixed number of bit times after that identifier, and it shuts again at the next end-of-packet. While the low-speed window is open, the full-speed ports keep receiving the same data.

The block also keeps a frame timer. The timer advances once per bit time and starts again from zero on every start-of-frame token.

Top module: `hub_rpt_gate`

## Requirements
- R1: When the upstream line shows K (`{dp,dm}=01`) on a bit strobe while the repeater is idle, `dn_drv_en` equals the enabled full-speed ports from the next cycle on, and `dn_ls_mode` stays 0.
- R2: When an enabled downstream port shows its speed's K on a bit strobe while idle (full speed `01`, low speed `10`), `up_drv_en` rises and `dn_drv_en` stays 0. The lowest-numbered active port becomes the source. If the upstream line starts a packet in the same strobe, the upstream packet wins.
- R3: On an `port_attach` pulse, a port whose line is `10` (D+ high) is classed as full speed, and a port whose line is `01` (D- high) is classed as low speed.
- R4: A low-speed port is never driven unless a preamble identifier has been seen. A non-preamble identifier does not open the window.
- R5: The preamble identifier 8'h3C, accepted during a downstream packet, asserts both `dn_drv_en` and `dn_ls_mode` for the enabled low-speed ports in the cycle after the LS_DELAY-th bit strobe that follows it (default 4, never more than 4). The full-speed ports stay driven.
- R6: An end-of-packet is SE0 (`00`) on at least two consecutive strobes followed by the source's J. All drivers go off on the next cycle, and the low-speed window closes. A single SE0 followed by J is not an end-of-packet.
- R7: `frame_cnt` advances by one per bit strobe and wraps from FRAME_BITS-1 to 0. The start-of-frame identifier 8'hA5 forces it to 0 on the next cycle, and this holds even when a strobe arrives in the same cycle.
- R8: Activity on a downstream port whose `port_en` bit is 0 starts no packet.
- R9: A preamble identifier that arrives while the repeater is idle is ignored, so the next downstream packet leaves the low-speed ports undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tick | input | 1 | One-cycle strobe per full-speed bit time |
| up_line | input | 2 | Upstream line state `{dp,dm}` |
| dn_line | input | 2*N_PORTS | Downstream line states, port i at bits [2i+1:2i] |
| port_en | input | N_PORTS | Per-port enable |
| port_attach | input | N_PORTS | Per-port attach pulse that latches speed |
| pid_valid | input | 1 | Qualifies `pid` |
| pid | input | 8 | Decoded identifier from upstream |
| up_drv_en | output | 1 | Upstream driver enable (full speed) |
| dn_drv_en | output | N_PORTS | Downstream driver enables |
| dn_ls_mode | output | N_PORTS | Low-speed driver mode per port |
| frame_cnt | output | $clog2(FRAME_BITS) | Frame timer in bit times |

## Verification
Two pairs of events can land in the same cycle. The first is a packet start on the upstream line together with a K on one or more enabled downstream ports. The bench drives both on a single strobe and expects the downstream direction, with no upstream driving. It then puts a K on two downstream ports at once and ends the packet on the lower-numbered port only, to show that port was the one chosen. The second pair is a start-of-frame identifier sharing its cycle with a bit strobe, and the bench expects the timer to read zero afterwards.

// File: rtl/hub_rpt_pkg.sv
package hub_rpt_pkg;

    typedef logic [1:0] line_t;

    // Line states as {dp, dm}
    localparam line_t LINE_SE0 = 2'b00;
    localparam line_t LINE_DP  = 2'b10;
    localparam line_t LINE_DM  = 2'b01;

    localparam logic [7:0] PID_PRE = 8'h3C;
    localparam logic [7:0] PID_SOF = 8'hA5;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } dir_e;

    // Idle (J) level for a port of the given speed
    function automatic line_t idle_j(input logic is_ls);
        return is_ls ? LINE_DM : LINE_DP;
    endfunction

    // Start-of-packet (K) level for a port of the given speed
    function automatic line_t start_k(input logic is_ls);
        return is_ls ? LINE_DP : LINE_DM;
    endfunction

endpackage

// File: rtl/hub_speed_latch.sv
module hub_speed_latch import hub_rpt_pkg::*; #(
    parameter int N_PORTS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_PORTS-1:0]     port_attach,
    input  logic [2*N_PORTS-1:0]   dn_line,
    output logic [N_PORTS-1:0]     ls_port
);
    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        line_t ln;
        assign ln = dn_line[2*g +: 2];
        always_ff @(posedge clk) begin
            if (rst) begin
                ls_port[g] <= 1'b0;
            end else if (port_attach[g]) begin
                if (ln == LINE_DM)      ls_port[g] <= 1'b1;
                else if (ln == LINE_DP) ls_port[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hub_eop_detect.sv
module hub_eop_detect import hub_rpt_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  active,
    input  line_t line,
    input  line_t j_level,
    output logic  eop
);
    logic [1:0] se0_run;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            se0_run <= '0;
        end else if (tick) begin
            if (line == LINE_SE0)
                se0_run <= (se0_run == 2'd3) ? se0_run : se0_run + 2'd1;
            else
                se0_run <= '0;
        end
    end

    assign eop = tick && active && (line == j_level) && (se0_run >= 2'd2);
endmodule

// File: rtl/hub_pre_window.sv
module hub_pre_window #(
    parameter int LS_DELAY = 4,
    localparam int DW = $clog2(LS_DELAY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic close,
    output logic open
);
    logic          armed;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || close) begin
            armed <= 1'b0;
            cnt   <= '0;
            open  <= 1'b0;
        end else if (start) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (tick && armed) begin
            if (cnt == DW'(LS_DELAY - 1)) begin
                open  <= 1'b1;
                armed <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hub_frame_timer.sv
module hub_frame_timer #(
    parameter int FRAME_BITS = 12000,
    localparam int FW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          sof,
    output logic [FW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || sof)
            count <= '0;
        else if (tick)
            count <= (count == FW'(FRAME_BITS - 1)) ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/hub_rpt_gate.sv
module hub_rpt_gate import hub_rpt_pkg::*; #(
    parameter int N_PORTS    = 4,
    parameter int LS_DELAY   = 4,
    parameter int FRAME_BITS = 12000,
    localparam int FW = $clog2(FRAME_BITS),
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fs_tick,
    input  logic [1:0]           up_line,
    input  logic [2*N_PORTS-1:0] dn_line,
    input  logic [N_PORTS-1:0]   port_en,
    input  logic [N_PORTS-1:0]   port_attach,
    input  logic                 pid_valid,
    input  logic [7:0]           pid,
    output logic                 up_drv_en,
    output logic [N_PORTS-1:0]   dn_drv_en,
    output logic [N_PORTS-1:0]   dn_ls_mode,
    output logic [FW-1:0]        frame_cnt
);
    dir_e               dir_q;
    logic [PW-1:0]      src_q;
    logic [N_PORTS-1:0] ls_port;
    logic [N_PORTS-1:0] dn_req;
    logic [PW-1:0]      pick;
    logic               up_req;
    line_t              src_line;
    line_t              src_j;
    logic               eop;
    logic               ls_open;
    logic               pre_start;
    logic               sof;

    hub_speed_latch #(.N_PORTS(N_PORTS)) u_speed (
        .clk(clk), .rst(rst), .port_attach(port_attach),
        .dn_line(dn_line), .ls_port(ls_port)
    );

    // Requests and lowest-index source pick
    always_comb begin
        dn_req = '0;
        pick   = '0;
        for (int i = 0; i < N_PORTS; i++)
            dn_req[i] = port_en[i] && (dn_line[2*i +: 2] == start_k(ls_port[i]));
        for (int i = N_PORTS - 1; i >= 0; i--)
            if (dn_req[i]) pick = PW'(i);
    end

    assign up_req = (up_line == LINE_DM);

    // Source line for end-of-packet tracking
    always_comb begin
        if (dir_q == DIR_UP) begin
            src_line = dn_line[2*src_q +: 2];
            src_j    = idle_j(ls_port[src_q]);
        end else begin
            src_line = up_line;
            src_j    = LINE_DP;
        end
    end

    hub_eop_detect u_eop (
        .clk(clk), .rst(rst), .tick(fs_tick), .active(dir_q != DIR_IDLE),
        .line(src_line), .j_level(src_j), .eop(eop)
    );

    assign pre_start = pid_valid && (pid == PID_PRE) && (dir_q == DIR_DOWN);
    assign sof       = pid_valid && (pid == PID_SOF);

    hub_pre_window #(.LS_DELAY(LS_DELAY)) u_pre (
        .clk(clk), .rst(rst), .tick(fs_tick), .start(pre_start),
        .close(eop), .open(ls_open)
    );

    hub_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst(rst), .tick(fs_tick), .sof(sof), .count(frame_cnt)
    );

    // Direction control
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_IDLE;
            src_q <= '0;
        end else begin
            unique case (dir_q)
                DIR_IDLE: if (fs_tick) begin
                    if (up_req) begin
                        dir_q <= DIR_DOWN;
                    end else if (|dn_req) begin
                        dir_q <= DIR_UP;
                        src_q <= pick;
                    end
                end
                DIR_DOWN, DIR_UP: if (eop) dir_q <= DIR_IDLE;
                default: dir_q <= DIR_IDLE;
            endcase
        end
    end

    // Driver enables
    logic [N_PORTS-1:0] fs_fwd, ls_fwd;
    assign fs_fwd     = port_en & ~ls_port;
    assign ls_fwd     = port_en & ls_port & {N_PORTS{ls_open}};
    assign dn_drv_en  = (dir_q == DIR_DOWN) ? (fs_fwd | ls_fwd) : '0;
    assign dn_ls_mode = (dir_q == DIR_DOWN) ? ls_fwd : '0;
    assign up_drv_en  = (dir_q == DIR_UP);
endmodule

// File: rtl/hub_rpt_gate_chk.sv
module hub_rpt_gate_chk import hub_rpt_pkg::*; #(
    parameter int N_PORTS    = 4,
    parameter int LS_DELAY   = 4,
    parameter int FRAME_BITS = 12000,
    localparam int FW = $clog2(FRAME_BITS)
) (
    input logic               clk,
    input logic               rst,
    input logic               fs_tick,
    input logic [N_PORTS-1:0] port_en,
    input logic               pid_valid,
    input logic [7:0]         pid,
    input logic               up_drv_en,
    input logic [N_PORTS-1:0] dn_drv_en,
    input logic [N_PORTS-1:0] dn_ls_mode,
    input logic [FW-1:0]      frame_cnt
);
    logic       pre_seen;
    logic [7:0] since_pre;
    logic       ls_any_q;
    logic       ls_any;

    assign ls_any = |dn_ls_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_seen  <= 1'b0;
            since_pre <= '0;
            ls_any_q  <= 1'b0;
        end else begin
            ls_any_q <= ls_any;
            if (pid_valid && pid == PID_PRE) begin
                pre_seen  <= 1'b1;
                since_pre <= '0;
            end else begin
                if (ls_any_q && !ls_any) pre_seen <= 1'b0;
                if (fs_tick && since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
            end
        end
    end

    // R2: one direction at a time
    p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
        !(up_drv_en && |dn_drv_en));

    // R8: a disabled port is never driven
    p_en_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (dn_drv_en & ~port_en) == '0);

    // R4 / R5: low-speed opening only after a preamble, within LS_DELAY strobes
    p_ls_after_pre_r5: assert property (@(posedge clk) disable iff (rst)
        (ls_any && !ls_any_q) |-> (pre_seen && int'(since_pre) <= LS_DELAY));

    // R6: upstream driver only drops on a bit strobe
    p_up_off_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(up_drv_en) |-> $past(fs_tick));

    // R7: start-of-frame zeroes the timer
    p_sof_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (pid_valid && pid == PID_SOF) |=> (frame_cnt == '0));

    // R7: timer steps by one per strobe
    p_frame_step_r7: assert property (@(posedge clk) disable iff (rst)
        (fs_tick && !(pid_valid && pid == PID_SOF) && frame_cnt != FW'(FRAME_BITS - 1))
        |=> (frame_cnt == $past(frame_cnt) + 1'b1));
endmodule

bind hub_rpt_gate hub_rpt_gate_chk #(
    .N_PORTS(N_PORTS), .LS_DELAY(LS_DELAY), .FRAME_BITS(FRAME_BITS)
) u_chk (
    .clk(clk), .rst(rst), .fs_tick(fs_tick), .port_en(port_en),
    .pid_valid(pid_valid), .pid(pid), .up_drv_en(up_drv_en),
    .dn_drv_en(dn_drv_en), .dn_ls_mode(dn_ls_mode), .frame_cnt(frame_cnt)
);

// File: tb/tb_hub_rpt_gate.sv
module tb_hub_rpt_gate;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int FRAME_BITS = 12000;
    localparam int FW         = $clog2(FRAME_BITS);

    logic          clk = 1'b0;
    logic          rst;
    logic          fs_tick;
    logic [1:0]    up_line;
    logic [2*N-1:0] dn_line;
    logic [N-1:0]  port_en;
    logic [N-1:0]  port_attach;
    logic          pid_valid;
    logic [7:0]    pid;
    logic          up_drv_en;
    logic [N-1:0]  dn_drv_en;
    logic [N-1:0]  dn_ls_mode;
    logic [FW-1:0] frame_cnt;

    int checks = 0;
    int fails  = 0;

    // ports 3..0: LS, FS, LS, FS idle levels
    localparam logic [7:0] DN_IDLE = 8'b01_10_01_10;

    always #(CLK_PERIOD/2) clk = ~clk;

    hub_rpt_gate #(.N_PORTS(N), .LS_DELAY(4), .FRAME_BITS(FRAME_BITS)) dut (
        .clk(clk), .rst(rst), .fs_tick(fs_tick), .up_line(up_line),
        .dn_line(dn_line), .port_en(port_en), .port_attach(port_attach),
        .pid_valid(pid_valid), .pid(pid), .up_drv_en(up_drv_en),
        .dn_drv_en(dn_drv_en), .dn_ls_mode(dn_ls_mode), .frame_cnt(frame_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dn_with(input int p, input logic [1:0] v);
        logic [7:0] d = DN_IDLE;
        d[2*p +: 2] = v;
        return d;
    endfunction

    task automatic bt(input logic [1:0] u, input logic [7:0] d);
        @(negedge clk);
        up_line = u; dn_line = d; fs_tick = 1'b1;
        @(negedge clk);
        fs_tick = 1'b0;
    endtask

    task automatic idle_bt();
        bt(2'b10, DN_IDLE);
    endtask

    task automatic send_pid(input logic [7:0] v, input logic with_tick);
        @(negedge clk);
        pid_valid = 1'b1; pid = v; fs_tick = with_tick;
        @(negedge clk);
        pid_valid = 1'b0; fs_tick = 1'b0;
    endtask

    task automatic up_eop();
        bt(2'b00, DN_IDLE);
        bt(2'b00, DN_IDLE);
        bt(2'b10, DN_IDLE);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R2 reset up_drv_en", 32'(up_drv_en), 0);
        chk("R1 reset dn_drv_en", 32'(dn_drv_en), 0);
        chk("R7 reset frame_cnt", 32'(frame_cnt), 0);
    endtask

    task automatic t_attach_and_fs();
        @(negedge clk);
        dn_line = DN_IDLE; port_attach = 4'hF;
        @(negedge clk);
        port_attach = 4'h0; port_en = 4'b0111;
        bt(2'b01, DN_IDLE);
        chk("R3 speed classes via drive", 32'(dn_drv_en), 32'h5);
        chk("R1 no ls mode", 32'(dn_ls_mode), 0);
        bt(2'b10, DN_IDLE);
        bt(2'b01, DN_IDLE);
        chk("R1 held during packet", 32'(dn_drv_en), 32'h5);
        bt(2'b00, DN_IDLE);
        bt(2'b10, DN_IDLE);
        chk("R6 single SE0 not eop", 32'(dn_drv_en), 32'h5);
        bt(2'b00, DN_IDLE);
        bt(2'b00, DN_IDLE);
        chk("R6 before J", 32'(dn_drv_en), 32'h5);
        bt(2'b10, DN_IDLE);
        chk("R6 eop drivers off", 32'(dn_drv_en), 0);
    endtask

    task automatic t_preamble();
        bt(2'b01, DN_IDLE);
        send_pid(8'h69, 1'b0);
        for (int k = 0; k < 5; k++) bt((k % 2 == 0) ? 2'b10 : 2'b01, DN_IDLE);
        chk("R4 non-preamble keeps ls closed", 32'(dn_drv_en), 32'h5);
        chk("R4 ls mode off", 32'(dn_ls_mode), 0);
        send_pid(8'h3C, 1'b0);
        for (int k = 0; k < 3; k++) bt((k % 2 == 0) ? 2'b10 : 2'b01, DN_IDLE);
        chk("R5 not yet open after 3", 32'(dn_ls_mode), 0);
        bt(2'b10, DN_IDLE);
        chk("R5 open drive", 32'(dn_drv_en), 32'h7);
        chk("R5 open ls mode", 32'(dn_ls_mode), 32'h2);
        up_eop();
        chk("R6 window closed drive", 32'(dn_drv_en), 0);
        chk("R6 window closed mode", 32'(dn_ls_mode), 0);
        bt(2'b01, DN_IDLE);
        chk("R6 next packet fs only", 32'(dn_drv_en), 32'h5);
        up_eop();
    endtask

    task automatic t_pre_idle();
        send_pid(8'h3C, 1'b0);
        bt(2'b01, DN_IDLE);
        for (int k = 0; k < 5; k++) bt((k % 2 == 0) ? 2'b10 : 2'b01, DN_IDLE);
        chk("R9 idle preamble ignored", 32'(dn_drv_en), 32'h5);
        chk("R9 ls mode off", 32'(dn_ls_mode), 0);
        up_eop();
    endtask

    task automatic t_upstream_src();
        bt(2'b10, dn_with(2, 2'b01));
        chk("R2 fs source up", 32'(up_drv_en), 1);
        chk("R2 no down drive", 32'(dn_drv_en), 0);
        bt(2'b10, dn_with(2, 2'b10));
        bt(2'b10, dn_with(2, 2'b00));
        bt(2'b10, dn_with(2, 2'b00));
        bt(2'b10, dn_with(2, 2'b10));
        chk("R6 fs source eop", 32'(up_drv_en), 0);
        bt(2'b10, dn_with(1, 2'b10));
        chk("R2 ls source up", 32'(up_drv_en), 1);
        bt(2'b10, dn_with(1, 2'b00));
        bt(2'b10, dn_with(1, 2'b00));
        bt(2'b10, dn_with(1, 2'b01));
        chk("R6 ls source eop on its J", 32'(up_drv_en), 0);
    endtask

    task automatic t_simultaneous();
        logic [7:0] d;
        bt(2'b01, dn_with(0, 2'b01));
        chk("R2 upstream wins dir", 32'(up_drv_en), 0);
        chk("R2 upstream wins drive", 32'(dn_drv_en), 32'h5);
        up_eop();
        d = DN_IDLE; d[1:0] = 2'b01; d[5:4] = 2'b01;
        bt(2'b10, d);
        chk("R2 two sources up", 32'(up_drv_en), 1);
        d[1:0] = 2'b00;
        bt(2'b10, d);
        bt(2'b10, d);
        d[1:0] = 2'b10;
        bt(2'b10, d);
        chk("R2 lowest port was source", 32'(up_drv_en), 0);
        idle_bt();
    endtask

    task automatic t_disabled();
        bt(2'b10, dn_with(3, 2'b10));
        chk("R8 disabled port ignored", 32'(up_drv_en), 0);
        chk("R8 no down drive", 32'(dn_drv_en), 0);
        idle_bt();
    endtask

    task automatic t_frame();
        send_pid(8'hA5, 1'b0);
        chk("R7 sof zero", 32'(frame_cnt), 0);
        for (int k = 0; k < 5; k++) idle_bt();
        chk("R7 count five", 32'(frame_cnt), 5);
        send_pid(8'hA5, 1'b1);
        chk("R7 sof with tick", 32'(frame_cnt), 0);
        for (int k = 0; k < FRAME_BITS - 1; k++) idle_bt();
        chk("R7 top value", 32'(frame_cnt), FRAME_BITS - 1);
        idle_bt();
        chk("R7 wrap", 32'(frame_cnt), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; fs_tick = 1'b0; up_line = 2'b10; dn_line = DN_IDLE;
        port_en = '0; port_attach = '0; pid_valid = 1'b0; pid = '0;
        t_reset();
        t_attach_and_fs();
        t_preamble();
        t_pre_idle();
        t_upstream_src();
        t_simultaneous();
        t_disabled();
        t_frame();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule